// File: doc/BRIEF.md
# Indirect Pointer Address Mapper

This block takes a 16-bit indirect pointer and decodes it into the physical target it selects. The target is one of three kinds. The first is a location in the banked data memory, given as a bank number and an in-bank offset. The second is a word in program memory. The third is a reserved hole that must not be touched. Pointer arithmetic and the memories themselves sit outside this block. The mapper only decodes.

The data view has two forms. In the first, a low pointer carries the bank directly in bits [11:7] and the offset in bits [6:0]. In the second, a linear window strings together the 80-byte general-purpose slices of consecutive banks, so firmware can treat them as one flat array. The mapper turns a linear pointer back into a bank and an offset by dividing by the slice size. Setting the pointer's top bit selects program memory instead.

A request strobe captures the pointer and a write/read qualifier. The decoded result appears one clock later together with a valid pulse. The result also carries two qualified indications: a write permission that is withheld for reserved targets, and a read-as-zero indication for reads of reserved targets.

Top module: `ind_addr_map`

## Requirements
- R1: After reset, `out_vld`, every field, every select and every qualifier output are 0.
- R2: `out_vld` is 1 in exactly the cycle after a cycle with `req` high, and 0 otherwise.
- R3: A pointer in 0x0000–0x0FFF decodes as data with `bank_o` = ptr[11:7] and `ofs_o` = ptr[6:0].
- R4: A pointer in 0x2000–0x29FF decodes as data. With L = ptr − 0x2000, `bank_o` = L / 80 and `ofs_o` = 0x20 + (L mod 80). For example, 0x2050 gives bank 1, offset 0x20.
- R5: `rgn_o` classifies the decoded offset: 0 below 0x0C (core), 1 for 0x0C–0x1F (peripheral), 2 for 0x20–0x6F (general RAM), 3 for 0x70–0x7F (shared). It is 0 for program and reserved results.
- R6: A pointer with bit 15 set gives `sel_prog_o` = 1 and `prog_o` = ptr[14:0], with bank and offset 0.
- R7: Pointers in 0x1000–0x1FFF and 0x2A00–0x7FFF give `invalid_o` = 1, both selects 0, and bank, offset and program address 0.
- R8: `wr_ok_o` is 1 only in a valid cycle whose captured `wr` was 1 and whose result is not reserved.
- R9: `rd_zero_o` is 1 only in a valid cycle whose captured `wr` was 0 and whose result is reserved.
- R10: In every valid cycle, exactly one of `sel_data_o`, `sel_prog_o` and `invalid_o` is 1.
- R11: Decoded fields keep their value in cycles where no request was captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Capture strobe for `ptr` and `wr` |
| wr | input | 1 | 1 = the access is a write, 0 = a read |
| ptr | input | 16 | Indirect pointer value |
| out_vld | output | 1 | Decoded result is new this cycle |
| bank_o | output | 5 | Data bank number |
| ofs_o | output | 7 | Offset within the bank |
| prog_o | output | 15 | Program-memory word address |
| rgn_o | output | 2 | In-bank region class |
| sel_data_o | output | 1 | Target is data memory |
| sel_prog_o | output | 1 | Target is program memory |
| invalid_o | output | 1 | Target is reserved |
| wr_ok_o | output | 1 | Write may proceed |
| rd_zero_o | output | 1 | Read must return zero |

## Verification
Two functions can meet in one valid cycle: the write qualifier, and the detection of a reserved range. A write strobe can land on a pointer just past the end of the linear window (0x2A00) or of the banked window (0x1000). It can also land on the last legal linear byte (0x29FF), where the division produces its largest bank and remainder. The bench drives exactly these pointers with `wr` high and low in consecutive cycles. It then judges `wr_ok_o`, `rd_zero_o` and `invalid_o` against a behavioural model. That model recomputes the target by integer division for every clock.

// File: rtl/iam_pkg.sv
package iam_pkg;
   localparam int PTR_W  = 16;
   localparam int BANK_W = 5;
   localparam int OFS_W  = 7;
   localparam int PROG_W = PTR_W - 1;

   typedef enum logic [1:0] {
      RG_CORE   = 2'd0,
      RG_PERIPH = 2'd1,
      RG_GPR    = 2'd2,
      RG_COMMON = 2'd3
   } rgn_e;

   typedef struct packed {
      logic              sel_data;
      logic              sel_prog;
      logic              invalid;
      logic [BANK_W-1:0] bank;
      logic [OFS_W-1:0]  ofs;
      logic [PROG_W-1:0] prog;
      rgn_e              rgn;
   } dec_t;
endpackage

// File: rtl/iam_lin_div.sv
// Divides a linear byte index by the general-RAM slice size.
// DIV_IMPL = 0: restoring shift-subtract chain (any slice size).
// DIV_IMPL = 1: reciprocal multiply, valid only for a slice of 80.
module iam_lin_div #(
   parameter int LW       = 12,
   parameter int QW       = 5,
   parameter int RW       = 7,
   parameter int SLICE    = 80,
   parameter int DIV_IMPL = 0
) (
   input  logic [LW-1:0] lin,
   output logic [QW-1:0] quo,
   output logic [RW-1:0] rem
);
   localparam int DW = LW + 1;

   if (SLICE < 2) begin : g_chk_slice
      $error("iam_lin_div: SLICE must be at least 2");
   end

   if (DIV_IMPL == 0) begin : g_restoring
      logic [DW-1:0] part [QW+1];
      logic [QW-1:0] qbit;
      assign part[QW] = DW'(lin);
      for (genvar k = QW - 1; k >= 0; k--) begin : g_stage
         localparam logic [DW-1:0] STEP = DW'(SLICE * (1 << k));
         always_comb begin
            if (part[k+1] >= STEP) begin
               qbit[k] = 1'b1;
               part[k] = part[k+1] - STEP;
            end else begin
               qbit[k] = 1'b0;
               part[k] = part[k+1];
            end
         end
      end
      assign quo = qbit;
      assign rem = RW'(part[0]);
   end else begin : g_recip
      if (SLICE != 80 || LW != 12 || QW != 5 || RW != 7) begin : g_chk_recip
         $error("iam_lin_div: reciprocal variant needs SLICE 80, LW 12, QW 5, RW 7");
      end
      // lin / 80 = (lin >> 4) / 5 ; (h * 205) >> 10 is exact for h < 160
      logic [7:0]  hi;
      logic [15:0] prod;
      logic [2:0]  r5;
      assign hi   = lin[11:4];
      assign prod = 16'(hi) * 16'd205;
      assign quo  = 5'(prod >> 10);
      assign r5   = 3'(hi - ({3'b000, quo} * 8'd5));
      assign rem  = {r5, lin[3:0]};
   end
endmodule

// File: rtl/iam_classify.sv
module iam_classify
   import iam_pkg::*;
#(
   parameter int BANKED_END  = 'h0FFF,
   parameter int LIN_BASE    = 'h2000,
   parameter int LIN_END     = 'h29FF,
   parameter int CORE_END    = 'h0C,
   parameter int GPR_BASE    = 'h20,
   parameter int GPR_SIZE    = 80,
   parameter int COMMON_BASE = 'h70,
   parameter int DIV_IMPL    = 0
) (
   input  logic [PTR_W-1:0] ptr,
   output dec_t             dec
);
   localparam int LSPAN = LIN_END - LIN_BASE + 1;
   localparam int LW    = $clog2(LSPAN);
   localparam int RW    = $clog2(GPR_SIZE);

   logic              top_bit, in_bank, in_lin;
   logic [LW-1:0]     lin;
   logic [BANK_W-1:0] lin_bank;
   logic [RW-1:0]     lin_rem;
   logic [OFS_W-1:0]  ofs_sel;

   assign top_bit = ptr[PTR_W-1];
   assign in_bank = !top_bit && (ptr <= PTR_W'(BANKED_END));
   assign in_lin  = !top_bit && (ptr >= PTR_W'(LIN_BASE)) && (ptr <= PTR_W'(LIN_END));
   assign lin     = LW'(ptr - PTR_W'(LIN_BASE));

   iam_lin_div #(
      .LW(LW), .QW(BANK_W), .RW(RW), .SLICE(GPR_SIZE), .DIV_IMPL(DIV_IMPL)
   ) u_div (
      .lin(lin),
      .quo(lin_bank),
      .rem(lin_rem)
   );

   always_comb begin
      dec          = '0;
      ofs_sel      = '0;
      dec.sel_prog = top_bit;
      if (top_bit) begin
         dec.prog = ptr[PROG_W-1:0];
      end else if (in_bank) begin
         dec.sel_data = 1'b1;
         dec.bank     = ptr[OFS_W +: BANK_W];
         ofs_sel      = ptr[OFS_W-1:0];
      end else if (in_lin) begin
         dec.sel_data = 1'b1;
         dec.bank     = lin_bank;
         ofs_sel      = OFS_W'(GPR_BASE) + OFS_W'(lin_rem);
      end else begin
         dec.invalid  = 1'b1;
      end
      dec.ofs = ofs_sel;
      if (ofs_sel < OFS_W'(CORE_END))         dec.rgn = RG_CORE;
      else if (ofs_sel < OFS_W'(GPR_BASE))    dec.rgn = RG_PERIPH;
      else if (ofs_sel < OFS_W'(COMMON_BASE)) dec.rgn = RG_GPR;
      else                                    dec.rgn = RG_COMMON;
   end
endmodule

// File: rtl/iam_pipe.sv
module iam_pipe #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_chk_w
      $error("iam_pipe: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
   end
endmodule

// File: rtl/ind_addr_map.sv
module ind_addr_map
   import iam_pkg::*;
#(
   parameter int BANKED_END  = 'h0FFF,
   parameter int LIN_BASE    = 'h2000,
   parameter int LIN_END     = 'h29FF,
   parameter int CORE_END    = 'h0C,
   parameter int GPR_BASE    = 'h20,
   parameter int GPR_SIZE    = 80,
   parameter int COMMON_BASE = 'h70,
   parameter int DIV_IMPL    = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req,
   input  logic        wr,
   input  logic [15:0] ptr,
   output logic        out_vld,
   output logic [4:0]  bank_o,
   output logic [6:0]  ofs_o,
   output logic [14:0] prog_o,
   output logic [1:0]  rgn_o,
   output logic        sel_data_o,
   output logic        sel_prog_o,
   output logic        invalid_o,
   output logic        wr_ok_o,
   output logic        rd_zero_o
);
   localparam int DEC_W = $bits(dec_t);
   localparam int LSPAN = LIN_END - LIN_BASE + 1;

   if (GPR_BASE + GPR_SIZE != COMMON_BASE) begin : g_chk_layout
      $error("ind_addr_map: general RAM must end where shared memory starts");
   end
   if (LSPAN > GPR_SIZE * (1 << BANK_W)) begin : g_chk_span
      $error("ind_addr_map: linear window larger than all general RAM");
   end
   if (LIN_BASE <= BANKED_END) begin : g_chk_order
      $error("ind_addr_map: linear window overlaps banked window");
   end

   dec_t dec_d, dec_q;
   logic wr_q, vld_q;

   iam_classify #(
      .BANKED_END(BANKED_END), .LIN_BASE(LIN_BASE), .LIN_END(LIN_END),
      .CORE_END(CORE_END), .GPR_BASE(GPR_BASE), .GPR_SIZE(GPR_SIZE),
      .COMMON_BASE(COMMON_BASE), .DIV_IMPL(DIV_IMPL)
   ) u_cls (
      .ptr(ptr),
      .dec(dec_d)
   );

   iam_pipe #(.W(DEC_W + 1)) u_fields (
      .clk(clk), .rst_n(rst_n), .en(req),
      .d({dec_d, wr}), .q({dec_q, wr_q})
   );

   iam_pipe #(.W(1)) u_vld (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .d(req), .q(vld_q)
   );

   assign out_vld    = vld_q;
   assign bank_o     = dec_q.bank;
   assign ofs_o      = dec_q.ofs;
   assign prog_o     = dec_q.prog;
   assign rgn_o      = dec_q.rgn;
   assign sel_data_o = dec_q.sel_data;
   assign sel_prog_o = dec_q.sel_prog;
   assign invalid_o  = dec_q.invalid;
   assign wr_ok_o    = vld_q && wr_q && !dec_q.invalid;
   assign rd_zero_o  = vld_q && !wr_q && dec_q.invalid;

   // R2: a request yields a valid pulse on the next cycle only
   a_r2_vld_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> out_vld);
   a_r2_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !out_vld);
   // R10: one target kind per valid result
   a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $countones({sel_data_o, sel_prog_o, invalid_o}) == 1);
   // R8: writes never pass on a reserved target
   a_r8_wr_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok_o |-> (out_vld && !invalid_o));
   // R9: read-as-zero only on reserved targets
   a_r9_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_zero_o |-> (out_vld && invalid_o && !sel_data_o));
   // R11: fields hold without a request
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> ($stable(bank_o) && $stable(ofs_o) && $stable(prog_o)));
   // R7: reserved result carries no address
   a_r7_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
      invalid_o |-> (bank_o == '0 && ofs_o == '0 && prog_o == '0));
endmodule

// File: tb/ind_addr_map_bench.sv
`timescale 1ns/1ps
module ind_addr_map_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        wr = 1'b0;
   logic [15:0] ptr = '0;
   logic        out_vld, sel_data_o, sel_prog_o, invalid_o, wr_ok_o, rd_zero_o;
   logic [4:0]  bank_o;
   logic [6:0]  ofs_o;
   logic [14:0] prog_o;
   logic [1:0]  rgn_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // expectation state
   int e_vld = 0, e_bank = 0, e_ofs = 0, e_prog = 0, e_rgn = 0;
   int e_dat = 0, e_prg = 0, e_inv = 0, e_wr = 0;
   int p_req = 0, p_wr = 0, p_ptr = 0;

   always #2.5 clk = ~clk;

   ind_addr_map u_ind_addr_map (
      .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .ptr(ptr),
      .out_vld(out_vld), .bank_o(bank_o), .ofs_o(ofs_o), .prog_o(prog_o),
      .rgn_o(rgn_o), .sel_data_o(sel_data_o), .sel_prog_o(sel_prog_o),
      .invalid_o(invalid_o), .wr_ok_o(wr_ok_o), .rd_zero_o(rd_zero_o)
   );

   task automatic chk(input string tag, input int act, input int exp, input int p);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s ptr=%04h actual=%0h expected=%0h", tag, p, act, exp);
      end
   endtask

   task automatic model(input int p);
      e_bank = 0; e_ofs = 0; e_prog = 0; e_dat = 0; e_prg = 0; e_inv = 0;
      if (p >= 'h8000) begin
         e_prg = 1; e_prog = p - 'h8000;
      end else if (p <= 'h0FFF) begin
         e_dat = 1; e_bank = p / 128; e_ofs = p % 128;
      end else if (p >= 'h2000 && p <= 'h29FF) begin
         e_dat = 1; e_bank = (p - 'h2000) / 80; e_ofs = 32 + (p - 'h2000) % 80;
      end else begin
         e_inv = 1;
      end
      if (e_ofs < 12)       e_rgn = 0;
      else if (e_ofs < 32)  e_rgn = 1;
      else if (e_ofs < 112) e_rgn = 2;
      else                  e_rgn = 3;
   endtask

   int last_ptr = 0;

   task automatic compare();
      int p;
      p = last_ptr;
      chk("R2 out_vld", int'(out_vld), e_vld, p);
      chk(e_inv != 0 ? "R7 bank" : (e_prg != 0 ? "R6 bank" : "R3/R4 bank"), int'(bank_o), e_bank, p);
      chk(e_inv != 0 ? "R7 ofs" : (e_prg != 0 ? "R6 ofs" : "R3/R4 ofs"), int'(ofs_o), e_ofs, p);
      chk(e_prg != 0 ? "R6 prog" : "R7 prog", int'(prog_o), e_prog, p);
      chk("R5 rgn", int'(rgn_o), e_rgn, p);
      chk("R10 sel_data", int'(sel_data_o), e_dat, p);
      chk("R6 sel_prog", int'(sel_prog_o), e_prg, p);
      chk("R7 invalid", int'(invalid_o), e_inv, p);
      chk("R8 wr_ok", int'(wr_ok_o), (e_vld != 0 && e_wr != 0 && e_inv == 0) ? 1 : 0, p);
      chk("R9 rd_zero", int'(rd_zero_o), (e_vld != 0 && e_wr == 0 && e_inv != 0) ? 1 : 0, p);
   endtask

   // one cycle: settle expectation from the previous drive, compare, drive anew
   task automatic step(input bit r, input bit w, input int p);
      @(negedge clk);
      e_vld = p_req;
      if (p_req != 0) begin
         model(p_ptr);
         e_wr = p_wr;
         last_ptr = p_ptr;
      end
      compare();   // R11: fields unchanged when no request
      req = r; wr = w; ptr = 16'(p);
      p_req = int'(r); p_wr = int'(w); p_ptr = p;
   endtask

   initial begin
      int edge_ptr [20];
      edge_ptr = '{'h0000, 'h000B, 'h000C, 'h001F, 'h0020, 'h006F, 'h0070,
                   'h0FFF, 'h1000, 'h1FFF, 'h2000, 'h204F, 'h2050, 'h209F,
                   'h29FF, 'h2A00, 'h7FFF, 'h8000, 'hFFFF, 'h0F80};
      repeat (3) @(negedge clk);
      compare();   // R1: reset state all zero
      rst_n = 1'b1;
      // boundaries, write then read on the same pointer back to back
      for (int i = 0; i < 20; i++) begin
         step(1'b1, 1'b1, edge_ptr[i]);
         step(1'b1, 1'b0, edge_ptr[i]);
         step(1'b0, 1'b1, 'h5555);   // R11 idle with noisy inputs
      end
      // full linear window sweep (R4)
      for (int p = 'h2000; p <= 'h29FF; p++) step(1'b1, p[0], p);
      // banked window sweep (R3, R5)
      for (int p = 0; p < 'h1000; p += 7) step(1'b1, p[1], p);
      // random mix with gaps
      for (int i = 0; i < 3000; i++) begin
         int rv;
         rv = int'($urandom);
         step(rv[20:18] != 3'b000, rv[17], rv & 'hFFFF);
      end
      step(1'b0, 1'b0, 0);
      step(1'b0, 1'b0, 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule